// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Counter

This block holds a 16-bit counter that steps by one up or down under a count-enable and a direction input, and that can be cleared to zero in one cycle. It raises a TOP indication when the count equals a compare value supplied on a port, and a BOTTOM indication when the count is zero. A registered overflow flag records every upward wrap and is cleared by writing a one to it.

Software reaches the counter over an 8-bit bus with three addresses: the low byte, the high byte and the flag byte. The high-byte address never touches the counter directly. It always goes through a shared holding register. Reading the low byte copies the counter's high byte into the holding register, so a later read of the high address returns the matching half of the same snapshot. Writing the low byte loads the holding register and the written byte together, so the whole 16-bit value changes in a single cycle. The usual sequence is to read low then high, and to write high then low.

Top module: `tc16_byte_counter`

## Requirements
- R1: After a synchronous active-low reset the counter is 0x0000, the holding register is 0x00 (read at address 1) and the overflow flag is 0.
- R2: With count-enable high and no higher-priority action, the counter increments by one when the direction input is 0 and decrements by one when it is 1, wrapping modulo 2^16.
- R3: The clear input sets the counter to 0x0000 on the next edge and takes priority over a bus write to the low byte and over counting.
- R4: A bus write to the low byte takes priority over counting in the same cycle.
- R5: A read at address 0 returns the counter's low byte combinationally and copies the counter's high byte into the holding register at the next edge. A read at address 1 returns the holding register. A read at address 3 returns 0x00.
- R6: A write at address 1 loads the holding register only and leaves the counter unchanged.
- R7: A write at address 0 loads the counter with {holding register, written byte} in one cycle.
- R8: The TOP output is high exactly while the counter equals the compare input, and the BOTTOM output is high exactly while the counter is 0x0000.
- R9: The overflow flag sets when an effective up-count steps the counter from 0xFFFF to 0x0000. A down-count from 0x0000 to 0xFFFF and a loaded zero do not set it. Bit 0 of a read at address 2 returns the flag, and the upper bits read as 0.
- R10: Writing address 2 with bit 0 equal to 1 clears the flag, and writing it with bit 0 equal to 0 has no effect. If an overflow occurs in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Step the counter by one this cycle |
| cnt_down | input | 1 | Step direction: 0 up, 1 down |
| cnt_clr | input | 1 | Clear the counter to zero |
| top_val | input | 16 | Compare value for the TOP output |
| bus_addr | input | 2 | 0 low byte, 1 high byte (holding register), 2 flag byte |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| cnt_val | output | 16 | Current counter value |
| at_top | output | 1 | Counter equals top_val |
| at_bottom | output | 1 | Counter equals zero |
| ovf_irq | output | 1 | Overflow interrupt-request flag |

## Verification
The bench builds the block with its default 8-bit bus width, so the counter is 16 bits wide. With that width, writing 0xFF to the high byte and then to the low byte places the counter one step from the upward wrap, so overflow set, W1C clear and their same-cycle collision can be reached in a few cycles. At the same width, a random stream that mixes counting with bus traffic keeps the counter moving across byte carries. This tests whether a low-then-high read returns one coherent snapshot while the count advances between the two accesses.

// File: rtl/tc16_pkg.sv
// Shared definitions for the byte-accessed counter.
// Assumes a two-bit bus address; address 3 is unused and reads as zero.
package tc16_pkg;
    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tc16_count_core.sv
// Counter register with clear > load > step priority.
// Assumes ld_en and ld_val are already decoded by the bus bridge.
// wrap_up flags an effective up-step from all ones to zero.
module tc16_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             step_dn,
    input  logic             clr,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_up
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;

    // Next-state selection by priority.
    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (ld_en)
            cnt_d = ld_val;
        else if (step_en)
            cnt_d = step_dn ? cnt_q - ONE : cnt_q + ONE;
        else
            cnt_d = cnt_q;
    end

    // Up-wrap detect, only when the step actually takes effect.
    assign wrap_up = step_en && !step_dn && !clr && !ld_en && (cnt_q == ALL_ONES);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tc16_byte_bridge.sv
// Byte bus bridge: holding register for the upper byte, read mux, and
// decode of counter load and flag clear. Assumes no simultaneous read and
// write at different addresses (one address per cycle).
module tc16_byte_bridge
    import tc16_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             flag_q,
    output logic [BUS_W-1:0] rdata,
    output logic             ld_en,
    output logic [CNT_W-1:0] ld_val,
    output logic             flag_w1c,
    output logic [BUS_W-1:0] hold_q
);
    logic wr_low, wr_high, rd_low;

    // Access decode.
    assign wr_low   = wr && (addr == SEL_LOW);
    assign wr_high  = wr && (addr == SEL_HIGH);
    assign rd_low   = rd && (addr == SEL_LOW);
    assign flag_w1c = wr && (addr == SEL_FLAG) && wdata[0];

    // Atomic 16-bit load from holding register plus written byte.
    assign ld_en  = wr_low;
    assign ld_val = {hold_q, wdata};

    // Read data mux; upper half is only visible through the holding register.
    always_comb begin
        case (addr)
            SEL_LOW:  rdata = cnt_q[BUS_W-1:0];
            SEL_HIGH: rdata = hold_q;
            SEL_FLAG: rdata = {{(BUS_W-1){1'b0}}, flag_q};
            default:  rdata = '0;
        endcase
    end

    // Holding register: bus write to high, or snapshot on low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_high)
            hold_q <= wdata;
        else if (rd_low)
            hold_q <= cnt_q[CNT_W-1:BUS_W];
    end
endmodule

// File: rtl/tc16_ovf_flag.sv
// Sticky overflow flag: set wins over write-one-to-clear.
module tc16_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_q
);
    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_req)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/tc16_byte_counter.sv
// Top: byte-accessed up/down counter with TOP/BOTTOM status and an
// overflow interrupt flag. Counter width is twice the bus width.
module tc16_byte_counter #(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_down,
    input  logic             cnt_clr,
    input  logic [CNT_W-1:0] top_val,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [CNT_W-1:0] cnt_val,
    output logic             at_top,
    output logic             at_bottom,
    output logic             ovf_irq
);
    logic             ld_en;
    logic [CNT_W-1:0] ld_val;
    logic             wrap_up;
    logic             flag_w1c;
    logic [BUS_W-1:0] hold_q;

    tc16_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (cnt_en),
        .step_dn (cnt_down),
        .clr     (cnt_clr),
        .ld_en   (ld_en),
        .ld_val  (ld_val),
        .cnt_q   (cnt_val),
        .wrap_up (wrap_up)
    );

    tc16_byte_bridge #(.BUS_W(BUS_W)) u_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .cnt_q    (cnt_val),
        .flag_q   (ovf_irq),
        .rdata    (bus_rdata),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .flag_w1c (flag_w1c),
        .hold_q   (hold_q)
    );

    tc16_ovf_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wrap_up),
        .clr_req (flag_w1c),
        .flag_q  (ovf_irq)
    );

    // Status compares.
    assign at_top    = (cnt_val == top_val);
    assign at_bottom = (cnt_val == '0);
endmodule

// File: rtl/tc16_byte_counter_chk.sv
// Assertion checker for tc16_byte_counter, attached by bind below.
// Observes top ports plus the holding register and wrap pulse.
module tc16_byte_counter_chk #(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             cnt_down,
    input logic             cnt_clr,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] cnt_val,
    input logic             ovf_irq,
    input logic [BUS_W-1:0] hold_q,
    input logic             wrap_up
);
    logic wr_lo, rd_lo, wr_hi;
    assign wr_lo = bus_wr && (bus_addr == 2'd0);
    assign wr_hi = bus_wr && (bus_addr == 2'd1);
    assign rd_lo = bus_rd && (bus_addr == 2'd0);

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_val == '0));

    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_down && !cnt_clr && !wr_lo) |=> (cnt_val == $past(cnt_val) + 1'b1));

    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_down && !cnt_clr && !wr_lo) |=> (cnt_val == $past(cnt_val) - 1'b1));

    a_r7_atomic_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !cnt_clr) |=> (cnt_val == {$past(hold_q), $past(bus_wdata)}));

    a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !wr_hi) |=> (hold_q == $past(cnt_val[CNT_W-1:BUS_W])));

    a_r6_high_no_count_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !cnt_en && !cnt_clr) |=> $stable(cnt_val));

    a_r9_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up |=> ovf_irq);

    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && bus_wdata[0] && !wrap_up) |=> !ovf_irq);
endmodule

bind tc16_byte_counter tc16_byte_counter_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .cnt_down  (cnt_down),
    .cnt_clr   (cnt_clr),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val),
    .ovf_irq   (ovf_irq),
    .hold_q    (hold_q),
    .wrap_up   (wrap_up)
);

// File: tb/tb_tc16_byte_counter.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a reference model kept in bench variables.
module tb_tc16_byte_counter;
    localparam int BUS_W = 8;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cnt_en, cnt_down, cnt_clr;
    logic [CNT_W-1:0] top_val;
    logic [1:0]       bus_addr;
    logic             bus_wr, bus_rd;
    logic [BUS_W-1:0] bus_wdata;
    logic [BUS_W-1:0] bus_rdata;
    logic [CNT_W-1:0] cnt_val;
    logic             at_top, at_bottom, ovf_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state.
    logic [CNT_W-1:0] m_cnt;
    logic [BUS_W-1:0] m_hold;
    logic             m_ovf;

    always #2.5 clk = ~clk;

    tc16_byte_counter #(.BUS_W(BUS_W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_down(cnt_down),
        .cnt_clr(cnt_clr), .top_val(top_val), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_val(cnt_val), .at_top(at_top),
        .at_bottom(at_bottom), .ovf_irq(ovf_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt[BUS_W-1:0];
            2'd1: return m_hold;
            2'd2: return {{(BUS_W-1){1'b0}}, m_ovf};
            default: return '0;
        endcase
    endfunction

    // One cycle: drive at negedge, check combinational outputs, advance model,
    // check registered outputs at the following negedge.
    task automatic step(input logic en, input logic dn, input logic clr,
                        input logic wr, input logic rd, input logic [1:0] a,
                        input logic [BUS_W-1:0] wd, input logic [CNT_W-1:0] tv);
        logic wrap;
        string tag;
        cnt_en = en; cnt_down = dn; cnt_clr = clr; bus_wr = wr; bus_rd = rd;
        bus_addr = a; bus_wdata = wd; top_val = tv;
        #1;
        check("R5 read data", bus_rdata, exp_rdata(a));
        check("R8 top", at_top, m_cnt == tv);
        check("R8 bottom", at_bottom, m_cnt == '0);
        wrap = en && !dn && !clr && !(wr && a == 2'd0) && m_cnt == 16'hFFFF;
        tag = clr ? "R3 clear" : (wr && a == 2'd0) ? "R7 R4 load" : en ? "R2 step" : "R6 hold";
        if (wr && a == 2'd1) m_hold = wd;
        else if (rd && a == 2'd0) m_hold = m_cnt[CNT_W-1:BUS_W];
        if (clr) m_cnt = '0;
        else if (wr && a == 2'd0) m_cnt = {(wr && a == 2'd1) ? wd : m_hold, wd};
        else if (en) m_cnt = dn ? m_cnt - 1'b1 : m_cnt + 1'b1;
        if (wrap) m_ovf = 1'b1;
        else if (wr && a == 2'd2 && wd[0]) m_ovf = 1'b0;
        @(negedge clk);
        check(tag, cnt_val, m_cnt);
        check("R9 R10 flag", ovf_irq, m_ovf);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 2'd3, 8'h00, 16'h1234);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [BUS_W-1:0] snap_lo;
        logic [CNT_W-1:0] snap;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        cnt_en = 0; cnt_down = 0; cnt_clr = 0; bus_wr = 0; bus_rd = 0;
        bus_addr = 0; bus_wdata = 0; top_val = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = '0; m_hold = '0; m_ovf = 1'b0;
        // R1 reset state
        check("R1 counter", cnt_val, 16'h0000);
        check("R1 flag", ovf_irq, 1'b0);
        bus_addr = 2'd1; #1;
        check("R1 holding", bus_rdata, 8'h00);
        @(negedge clk);

        // R2 up and down
        repeat (5) step(1, 0, 0, 0, 0, 2'd3, 0, 16'h0003);
        repeat (7) step(1, 1, 0, 0, 0, 2'd3, 0, 16'h0000);
        // R9: down wrap 0 -> FFFF does not set the flag
        step(1, 0, 0, 1, 0, 2'd0, 8'h00, 0); // load 0x0000 (R7)
        step(1, 1, 0, 0, 0, 2'd3, 0, 0);
        check("R9 down wrap no flag", ovf_irq, 1'b0);

        // R6 then R7: atomic high-then-low write to 0xFFFE
        step(0, 0, 0, 1, 0, 2'd1, 8'hFF, 0);
        check("R6 counter unchanged", cnt_val, 16'hFFFF);
        step(1, 0, 0, 1, 0, 2'd0, 8'hFE, 16'hFFFE); // R4 load beats step
        check("R7 atomic", cnt_val, 16'hFFFE);
        step(1, 0, 0, 0, 0, 2'd3, 0, 16'hFFFF);
        step(1, 0, 0, 0, 0, 2'd3, 0, 0);   // wrap -> flag
        check("R9 up wrap sets", ovf_irq, 1'b1);
        step(0, 0, 0, 1, 0, 2'd2, 8'hFE, 0); // bit0 = 0: no effect
        check("R10 write zero ignored", ovf_irq, 1'b1);
        step(0, 0, 0, 0, 1, 2'd2, 0, 0);
        step(0, 0, 0, 1, 0, 2'd2, 8'h01, 0);
        check("R10 w1c", ovf_irq, 1'b0);

        // R10 collision: set wins over clear
        step(0, 0, 0, 1, 0, 2'd1, 8'hFF, 0);
        step(0, 0, 0, 1, 0, 2'd0, 8'hFF, 0);
        bus_addr = 2'd2; bus_wdata = 8'h01;
        step(1, 0, 0, 1, 0, 2'd2, 8'h01, 0);
        check("R10 set beats clear", ovf_irq, 1'b1);
        step(0, 0, 0, 1, 0, 2'd2, 8'h01, 0);

        // R3 clear beats load and step
        step(0, 0, 0, 1, 0, 2'd1, 8'h5A, 0);
        step(1, 0, 1, 1, 0, 2'd0, 8'hA5, 0);
        check("R3 clear priority", cnt_val, 16'h0000);

        // R5 coherent snapshot while running across a byte carry
        step(0, 0, 0, 1, 0, 2'd1, 8'h12, 0);
        step(0, 0, 0, 1, 0, 2'd0, 8'hFE, 0);
        snap = cnt_val;
        cnt_en = 1; bus_rd = 1; bus_addr = 2'd0; #1;
        snap_lo = bus_rdata;
        step(1, 0, 0, 0, 1, 2'd0, 0, 0);
        step(1, 0, 0, 0, 1, 2'd0 + 2'd1, 0, 0);
        bus_addr = 2'd1; bus_rd = 1; cnt_en = 0; #1;
        check("R5 snapshot", {bus_rdata, snap_lo}, snap);
        @(negedge clk);
        step(0, 0, 0, 0, 1, 2'd3, 0, 0);
        check("R5 unused address", bus_rdata, 8'h00);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op = 4'($urandom_range(0, 15));
            logic [1:0] a  = 2'($urandom_range(0, 3));
            logic wr = (op == 4'd0) || (op == 4'd1);
            logic rd = (op == 4'd2) || (op == 4'd3);
            logic [CNT_W-1:0] tv = ($urandom_range(0, 3) == 0) ? m_cnt : 16'($urandom);
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 31) == 0), wr, rd, a, 8'($urandom), tv);
        end
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule